// File: doc/BRIEF.md
# Extended-Carry Add Execution Unit

This unit executes one 32-bit XO-form instruction per cycle from a small add-with-carry family. The family has three members: add-to-zero-extended (`RA + CA`), add-to-minus-one-extended (`RA + all-ones + CA`) and subtract-from-zero-extended (`~RA + CA`). With each instruction word the caller supplies the value of the source register and the current fixed-point exception bits: carry (CA), overflow (OV) and summary overflow (SO). One cycle later the unit returns several results, each with its own write enable:

- the destination register index and value;
- the new exception bits;
- a 4-bit condition field.

Typical uses are to close the top word of a multi-word addition chain, or to turn the carry bit into a plain 0/1 integer. Register file access, fetch and pipelining belong to the surrounding core. Words the unit does not support are flagged as illegal and cause no writes.

Top module: `xcarry_alu`

## Requirements
- R1: The unit decodes the word as follows, with bit 31 as the most significant bit.
  - A word is legal only when `instr[31:26]` equals 31 and the 9-bit minor code `instr[9:1]` is one of 202 (add-to-zero-extended), 234 (add-to-minus-one-extended) or 200 (subtract-from-zero-extended).
  - The destination index is `instr[25:21]`.
  - The overflow-enable bit is `instr[10]` and the record bit is `instr[0]`.
- R2: Add-to-zero-extended writes `RA + CA` modulo 2^32 to the destination.
- R3: Add-to-minus-one-extended writes `RA + 0xFFFFFFFF + CA` modulo 2^32.
- R4: Subtract-from-zero-extended writes `~RA + CA` modulo 2^32.
- R5: Every legal word writes CA with the unsigned carry out of bit 31 of its sum. For add-to-zero-extended this is 1 only for RA = 0xFFFFFFFF with CA = 1.
- R6: With the overflow-enable bit set, OV is written with the signed overflow of the sum, where the carry-in counts as part of that sum. With it clear, `ov_we` stays 0 and `ov_out` and `so_out` repeat the incoming OV and SO.
- R7: SO becomes 1 whenever this word sets OV, and an incoming SO of 1 is never cleared.
- R8: With the record bit set, `cr0_we` is 1 and `cr0` = {LT, GT, EQ, SO}, with LT in bit 3 and SO in bit 0.
  - LT, GT and EQ come from a signed comparison of the result with zero.
  - The SO bit is the value after this word's own update.
  - With the record bit clear, `cr0_we` is 0.
- R9: The value in the `instr[15:11]` slot has no effect on any output.
- R10: An illegal word raises `illegal` together with `out_valid` and keeps every write enable at 0. In that case `ca_out`, `ov_out` and `so_out` repeat the inputs.
- R11: All results appear one clock edge after the edge that samples `in_valid`. A cycle without `in_valid` yields `out_valid` = 0, `illegal` = 0 and all write enables at 0.
- R12: While `rst` is high, `out_valid`, `illegal` and every write enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| ra_val | input | XLEN | Source register value |
| xer_ca_in | input | 1 | Current carry bit |
| xer_ov_in | input | 1 | Current overflow bit |
| xer_so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Result of last cycle's word is present |
| illegal | output | 1 | Last cycle's word was not supported |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Destination register value |
| ca_we | output | 1 | Carry write enable |
| ca_out | output | 1 | New carry bit |
| ov_we | output | 1 | Overflow and summary-overflow write enable |
| ov_out | output | 1 | New overflow bit |
| so_out | output | 1 | New summary-overflow bit |
| cr0_we | output | 1 | Condition field write enable |
| cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
All results of a word, including the illegal flag, sit in one register stage. They are therefore due exactly one rising edge after the edge that samples `in_valid`, and the outputs return to idle one edge after `in_valid` drops. The bench changes inputs on the falling edge, waits for the next rising edge and samples 1 ns after it, so it compares the output register written by that edge. A separate idle check one cycle later confirms that `out_valid` and the write enables fall again.

// File: rtl/xca_pkg.sv
package xca_pkg;

    // Instruction word geometry (bit 31 = most significant)
    localparam int INSN_W     = 32;
    localparam int PRIM_W     = 6;
    localparam int PRIM_LSB   = INSN_W - PRIM_W;
    localparam int REG_W      = 5;
    localparam int DST_LSB    = PRIM_LSB - REG_W;
    localparam int SRC_LSB    = DST_LSB - REG_W;
    localparam int SPARE_LSB  = SRC_LSB - REG_W;
    localparam int OE_POS     = SPARE_LSB - 1;
    localparam int MINOR_W    = 9;
    localparam int MINOR_LSB  = 1;
    localparam int REC_POS    = 0;
    localparam int CR_W       = 4;

    localparam logic [PRIM_W-1:0]  PRIM_ALU      = 6'd31;
    localparam logic [MINOR_W-1:0] MINOR_ZEXT    = 9'd202;
    localparam logic [MINOR_W-1:0] MINOR_MEXT    = 9'd234;
    localparam logic [MINOR_W-1:0] MINOR_SFZEXT  = 9'd200;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_ZEXT   = 2'd1,
        OP_MEXT   = 2'd2,
        OP_SFZEXT = 2'd3
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             legal;
        logic [REG_W-1:0] dst;
        logic             oe;
        logic             rec;
    } dec_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_t;

    function automatic op_e minor_to_op(input logic [MINOR_W-1:0] m);
        op_e r;
        case (m)
            MINOR_ZEXT:   r = OP_ZEXT;
            MINOR_MEXT:   r = OP_MEXT;
            MINOR_SFZEXT: r = OP_SFZEXT;
            default:      r = OP_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xca_decode.sv
module xca_decode
    import xca_pkg::*;
(
    input  logic [INSN_W-1:0] instr_i,
    output dec_t              dec_o
);
    logic [PRIM_W-1:0]  prim;
    logic [MINOR_W-1:0] minor;
    op_e                op;
    logic               unused_fields;

    assign prim  = instr_i[PRIM_LSB +: PRIM_W];
    assign minor = instr_i[MINOR_LSB +: MINOR_W];
    assign op    = (prim == PRIM_ALU) ? minor_to_op(minor) : OP_NONE;

    // Source index and spare slot play no part in this family
    assign unused_fields = ^{instr_i[SRC_LSB +: REG_W], instr_i[SPARE_LSB +: REG_W]};

    always_comb begin
        dec_o.op    = op;
        dec_o.legal = (op != OP_NONE);
        dec_o.dst   = instr_i[DST_LSB +: REG_W];
        dec_o.oe    = instr_i[OE_POS];
        dec_o.rec   = instr_i[REC_POS];
    end
endmodule

// File: rtl/xca_adder.sv
module xca_adder
    import xca_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op_i,
    input  logic [W-1:0] ra_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic [W:0]   wide;

    always_comb begin
        case (op_i)
            OP_MEXT:   begin opa = ra_i;  opb = '1; end
            OP_SFZEXT: begin opa = ~ra_i; opb = '0; end
            default:   begin opa = ra_i;  opb = '0; end
        endcase
    end

    assign wide   = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin_i};
    assign sum_o  = wide[MSB:0];
    assign cout_o = wide[W];
    // Like-signed operands giving a result of the other sign
    assign ovf_o  = (opa[MSB] == opb[MSB]) && (sum_o[MSB] != opa[MSB]);
endmodule

// File: rtl/xca_flags.sv
module xca_flags
    import xca_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         oe_i,
    input  logic [W-1:0] res_i,
    input  logic         ovf_i,
    input  logic         ov_i,
    input  logic         so_i,
    output logic         ov_o,
    output logic         so_o,
    output cr_t          cr_o
);
    localparam int MSB = W - 1;

    assign ov_o = oe_i ? ovf_i : ov_i;
    assign so_o = so_i | (oe_i & ovf_i);

    always_comb begin
        cr_o.lt = res_i[MSB];
        cr_o.eq = (res_i == '0);
        cr_o.gt = ~res_i[MSB] & (res_i != '0);
        cr_o.so = so_o;
    end
endmodule

// File: rtl/xcarry_alu.sv
module xcarry_alu
    import xca_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSN_W-1:0]   instr,
    input  logic [XLEN-1:0]     ra_val,
    input  logic                xer_ca_in,
    input  logic                xer_ov_in,
    input  logic                xer_so_in,
    output logic                out_valid,
    output logic                illegal,
    output logic                rd_we,
    output logic [REG_W-1:0]    rd_idx,
    output logic [XLEN-1:0]     rd_data,
    output logic                ca_we,
    output logic                ca_out,
    output logic                ov_we,
    output logic                ov_out,
    output logic                so_out,
    output logic                cr0_we,
    output logic [CR_W-1:0]     cr0
);
    dec_t            dec;
    logic [XLEN-1:0] sum;
    logic            cout;
    logic            sovf;
    logic            ov_n;
    logic            so_n;
    cr_t             cr_n;
    logic            go;

    xca_decode u_dec (
        .instr_i (instr),
        .dec_o   (dec)
    );

    xca_adder #(.W(XLEN)) u_add (
        .op_i   (dec.op),
        .ra_i   (ra_val),
        .cin_i  (xer_ca_in),
        .sum_o  (sum),
        .cout_o (cout),
        .ovf_o  (sovf)
    );

    xca_flags #(.W(XLEN)) u_flg (
        .oe_i  (dec.oe),
        .res_i (sum),
        .ovf_i (sovf),
        .ov_i  (xer_ov_in),
        .so_i  (xer_so_in),
        .ov_o  (ov_n),
        .so_o  (so_n),
        .cr_o  (cr_n)
    );

    assign go = in_valid & dec.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            rd_we     <= 1'b0;
            rd_idx    <= '0;
            rd_data   <= '0;
            ca_we     <= 1'b0;
            ca_out    <= 1'b0;
            ov_we     <= 1'b0;
            ov_out    <= 1'b0;
            so_out    <= 1'b0;
            cr0_we    <= 1'b0;
            cr0       <= '0;
        end else begin
            out_valid <= in_valid;
            illegal   <= in_valid & ~dec.legal;
            rd_we     <= go;
            ca_we     <= go;
            ov_we     <= go & dec.oe;
            cr0_we    <= go & dec.rec;
            rd_idx    <= go ? dec.dst : '0;
            rd_data   <= go ? sum : '0;
            ca_out    <= go ? cout : xer_ca_in;
            ov_out    <= go ? ov_n : xer_ov_in;
            so_out    <= go ? so_n : xer_so_in;
            cr0       <= (go & dec.rec) ? cr_n : '0;
        end
    end
endmodule

// File: rtl/xca_checker.sv
module xca_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] ra_val,
    input logic            xer_ca_in,
    input logic            xer_ov_in,
    input logic            xer_so_in,
    input logic            out_valid,
    input logic            illegal,
    input logic            rd_we,
    input logic [XLEN-1:0] rd_data,
    input logic            ca_we,
    input logic            ov_we,
    input logic            ov_out,
    input logic            so_out,
    input logic            cr0_we,
    input logic [3:0]      cr0
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !illegal && !rd_we && !ca_we && !ov_we && !cr0_we));

    a_r10_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (out_valid && !rd_we && !ca_we && !ov_we && !cr0_we));

    a_r5_carry_always: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal) |-> (ca_we && rd_we));

    a_r7_so_sticky: assert property (@(posedge clk) disable iff (rst)
        (in_valid && xer_so_in) |=> so_out);

    a_r6_hold_without_oe: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !instr[10]) |=>
            (!ov_we && ov_out == $past(xer_ov_in) && so_out == $past(xer_so_in)));

    a_r8_cr_so_copy: assert property (@(posedge clk) disable iff (rst)
        cr0_we |-> (cr0[0] == so_out && $countones(cr0[3:1]) == 1));

    a_r2_zext_sum: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[31:26] == 6'd31 && instr[9:1] == 9'd202) |=>
            (rd_data == XLEN'($past(ra_val) + XLEN'($past(xer_ca_in)))));
endmodule

bind xcarry_alu xca_checker #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr     (instr),
    .ra_val    (ra_val),
    .xer_ca_in (xer_ca_in),
    .xer_ov_in (xer_ov_in),
    .xer_so_in (xer_so_in),
    .out_valid (out_valid),
    .illegal   (illegal),
    .rd_we     (rd_we),
    .rd_data   (rd_data),
    .ca_we     (ca_we),
    .ov_we     (ov_we),
    .ov_out    (ov_out),
    .so_out    (so_out),
    .cr0_we    (cr0_we),
    .cr0       (cr0)
);

// File: tb/sim_xcarry_alu.sv
module sim_xcarry_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] ra_val = '0;
    logic        xer_ca_in = 1'b0;
    logic        xer_ov_in = 1'b0;
    logic        xer_so_in = 1'b0;
    logic        out_valid, illegal, rd_we, ca_we, ca_out, ov_we, ov_out, so_out, cr0_we;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;
    logic [3:0]  cr0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    xcarry_alu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .ra_val(ra_val),
        .xer_ca_in(xer_ca_in), .xer_ov_in(xer_ov_in), .xer_so_in(xer_so_in),
        .out_valid(out_valid), .illegal(illegal), .rd_we(rd_we), .rd_idx(rd_idx),
        .rd_data(rd_data), .ca_we(ca_we), .ca_out(ca_out), .ov_we(ov_we),
        .ov_out(ov_out), .so_out(so_out), .cr0_we(cr0_we), .cr0(cr0)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [8:0] minor, input logic [4:0] dst,
                                       input logic [4:0] src, input logic [4:0] spare,
                                       input logic oe, input logic rec);
        return {6'd31, dst, src, spare, oe, minor, rec};
    endfunction

    // Issue one word and compare every output against the requirement model
    task automatic run(input string req, input logic [31:0] w, input logic [31:0] a,
                       input logic ca, input logic ov, input logic so);
        logic        legal, e_ca, e_ov, e_so, oe, rec, sovf;
        logic [31:0] res;
        logic [32:0] t;
        longint      truesum;
        logic [3:0]  e_cr;
        legal = (w[31:26] == 6'd31) &&
                (w[9:1] == 9'd202 || w[9:1] == 9'd234 || w[9:1] == 9'd200);
        oe  = w[10];
        rec = w[0];
        case (w[9:1])
            9'd234: begin
                t = {1'b0, a} + 33'h0_FFFF_FFFF + {32'd0, ca};
                truesum = longint'($signed(a)) - 1 + longint'(ca);
            end
            9'd200: begin
                t = {1'b0, ~a} + {32'd0, ca};
                truesum = longint'($signed(~a)) + longint'(ca);
            end
            default: begin
                t = {1'b0, a} + {32'd0, ca};
                truesum = longint'($signed(a)) + longint'(ca);
            end
        endcase
        res  = t[31:0];
        sovf = (truesum != longint'($signed(res)));
        e_ca = legal ? t[32] : ca;
        e_ov = (legal && oe) ? sovf : ov;
        e_so = (legal && oe) ? (so | sovf) : so;
        e_cr = {$signed(res) < 0, $signed(res) > 0, res == 32'd0, e_so};

        @(negedge clk);
        in_valid = 1'b1; instr = w; ra_val = a;
        xer_ca_in = ca; xer_ov_in = ov; xer_so_in = so;
        @(posedge clk);
        #1;
        check(req, "out_valid", 32'(out_valid), 32'd1);
        check(req, "illegal",   32'(illegal),   32'(!legal));
        check(req, "rd_we",     32'(rd_we),     32'(legal));
        check(req, "ca_we",     32'(ca_we),     32'(legal));
        check(req, "ov_we",     32'(ov_we),     32'(legal && oe));
        check(req, "cr0_we",    32'(cr0_we),    32'(legal && rec));
        check(req, "ca_out",    32'(ca_out),    32'(e_ca));
        check(req, "ov_out",    32'(ov_out),    32'(e_ov));
        check(req, "so_out",    32'(so_out),    32'(e_so));
        if (legal) begin
            check(req, "rd_idx",  32'(rd_idx), 32'(w[25:21]));
            check(req, "rd_data", rd_data, res);
            if (rec) check(req, "cr0", 32'(cr0), 32'(e_cr));
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle_check;
        @(negedge clk);
        in_valid = 1'b0;
        instr = mk(9'd202, 5'd7, 5'd1, 5'd0, 1'b1, 1'b1);
        @(posedge clk);
        #1;
        check("R11", "idle out_valid", 32'(out_valid), 32'd0);
        check("R11", "idle writes", 32'({illegal, rd_we, ca_we, ov_we, cr0_we}), 32'd0);
    endtask

    task automatic t_reset;
        @(posedge clk);
        #1;
        check("R12", "reset out_valid", 32'(out_valid), 32'd0);
        check("R12", "reset writes", 32'({illegal, rd_we, ca_we, ov_we, cr0_we}), 32'd0);
    endtask

    task automatic t_zext;
        run("R2", mk(9'd202, 5'd3, 5'd4, 5'd0, 1'b0, 1'b0), 32'h0000_0010, 1'b1, 1'b0, 1'b0);
        run("R2", mk(9'd202, 5'd9, 5'd4, 5'd0, 1'b0, 1'b0), 32'h1234_5678, 1'b0, 1'b0, 1'b0);
        run("R2", mk(9'd202, 5'd1, 5'd0, 5'd0, 1'b0, 1'b0), 32'h0000_0000, 1'b1, 1'b0, 1'b0);
        run("R5", mk(9'd202, 5'd2, 5'd5, 5'd0, 1'b0, 1'b0), 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
        run("R5", mk(9'd202, 5'd2, 5'd5, 5'd0, 1'b0, 1'b0), 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        run("R1", mk(9'd202, 5'd31, 5'd5, 5'd0, 1'b0, 1'b0), 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_mext;
        run("R3", mk(9'd234, 5'd6, 5'd2, 5'd0, 1'b0, 1'b0), 32'h0000_0000, 1'b0, 1'b0, 1'b0);
        run("R3", mk(9'd234, 5'd6, 5'd2, 5'd0, 1'b0, 1'b0), 32'h0000_0000, 1'b1, 1'b0, 1'b0);
        run("R3", mk(9'd234, 5'd6, 5'd2, 5'd0, 1'b0, 1'b0), 32'h0000_0100, 1'b0, 1'b0, 1'b0);
        run("R6", mk(9'd234, 5'd8, 5'd2, 5'd0, 1'b1, 1'b0), 32'h8000_0000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_sfzext;
        run("R4", mk(9'd200, 5'd10, 5'd3, 5'd0, 1'b0, 1'b0), 32'h0000_0000, 1'b1, 1'b0, 1'b0);
        run("R4", mk(9'd200, 5'd10, 5'd3, 5'd0, 1'b0, 1'b0), 32'h0000_0005, 1'b0, 1'b0, 1'b0);
        run("R6", mk(9'd200, 5'd11, 5'd3, 5'd0, 1'b1, 1'b0), 32'h8000_0000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_overflow;
        run("R6", mk(9'd202, 5'd12, 5'd1, 5'd0, 1'b1, 1'b0), 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);
        run("R6", mk(9'd202, 5'd12, 5'd1, 5'd0, 1'b1, 1'b0), 32'h0000_0001, 1'b1, 1'b1, 1'b0);
        run("R6", mk(9'd202, 5'd12, 5'd1, 5'd0, 1'b0, 1'b0), 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0);
        run("R7", mk(9'd202, 5'd12, 5'd1, 5'd0, 1'b1, 1'b0), 32'h0000_0001, 1'b0, 1'b1, 1'b1);
        run("R7", mk(9'd234, 5'd12, 5'd1, 5'd0, 1'b1, 1'b0), 32'h8000_0000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_record;
        run("R8", mk(9'd202, 5'd13, 5'd1, 5'd0, 1'b0, 1'b1), 32'h0000_0000, 1'b0, 1'b0, 1'b0);
        run("R8", mk(9'd202, 5'd13, 5'd1, 5'd0, 1'b0, 1'b1), 32'h8000_0001, 1'b0, 1'b0, 1'b1);
        run("R8", mk(9'd234, 5'd13, 5'd1, 5'd0, 1'b0, 1'b1), 32'h0000_0005, 1'b1, 1'b0, 1'b0);
        run("R8", mk(9'd202, 5'd13, 5'd1, 5'd0, 1'b1, 1'b1), 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);
        run("R8", mk(9'd200, 5'd13, 5'd1, 5'd0, 1'b0, 1'b0), 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_spare;
        run("R9", mk(9'd202, 5'd14, 5'd1, 5'd31, 1'b1, 1'b1), 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);
        run("R9", mk(9'd200, 5'd14, 5'd1, 5'd21, 1'b0, 1'b1), 32'h0000_0001, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_illegal;
        run("R10", {6'd30, 5'd3, 5'd4, 5'd0, 1'b1, 9'd202, 1'b1}, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0);
        run("R10", mk(9'd266, 5'd3, 5'd4, 5'd0, 1'b1, 1'b1), 32'h0000_0001, 1'b1, 1'b1, 1'b0);
        run("R1",  mk(9'd138, 5'd3, 5'd4, 5'd0, 1'b0, 1'b0), 32'h0000_0001, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_zext();
        idle_check();
        t_mext();
        t_sfzext();
        idle_check();
        t_overflow();
        t_record();
        t_spare();
        t_illegal();
        idle_check();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule